// File: doc/BRIEF.md
# GPIO Line Event Interrupt Unit

This block is the interrupt section of one 32-line general-purpose I/O bank. It watches the synchronized pad levels of every line. For each line, a 3-bit selector supplied by the bank's configuration store picks which condition counts as an event for that line. The condition can be a rising edge, a falling edge, any edge, a low level or a high level.

A detected event sets the line's bit in a status word. Software reads the status word through a small register port, and that read empties the word. A per-line mask decides which pending bits reach the single interrupt output. Software sets mask bits by writing ones to an enable offset and clears them by writing ones to a disable offset.

Typical use is to program the selectors first, then enable the lines of interest. When the output rises, software reads the status word and services the lines whose bits are set in both the status word and the mask.

Top module: `gpio_evt_irq`

## Requirements
- R1: After a synchronous reset, the mask, the status word, the read data and `irq_o` are all zero.
- R2: Selector code 0 sets a line's status bit on the cycle its level goes from 1 to 0 compared with the previous cycle.
- R3: Selector code 1 sets a line's status bit on the cycle its level goes from 0 to 1.
- R4: Selector code 2 sets a line's status bit on any change of level between consecutive cycles.
- R5: Selector code 3 sets a line's status bit on every cycle the line is low. The bit therefore returns after a status read while the line stays low.
- R6: Selector code 4 sets a line's status bit on every cycle the line is high.
- R7: Selector codes 5, 6 and 7 never set a status bit.
- R8: A write to offset 0x20 sets the mask bits where the data has ones. A write to offset 0x24 clears the mask bits where the data has ones. Zero data bits leave the mask unchanged. A read at offset 0x28 returns the mask.
- R9: A read at offset 0x2C returns the status word on `bus_rdata_o` one cycle after the request, and clears every status bit. Status bits otherwise stay set, and reading the mask leaves them untouched.
- R10: An event detected in the same cycle as a status read stays set after the clear, and the next status read returns it.
- R11: Status bits are set whether or not the line is enabled in the mask. `irq_o` is high exactly when status AND mask is non-zero.
- R12: `irq_o` rises on the same clock edge that records an event on an enabled line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pad_lvl_i | input | 32 | Synchronized pad level of each line |
| evt_sel_i | input | 96 | Event selector per line, 3 bits each; line k uses bits 3k+2..3k |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data, one bit per line |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Bank interrupt, registered |

## Verification
A status read and a new event can land in the same clock cycle. The clear must then remove only the older bits and keep the new one. The bench provokes this by raising a line on the same cycle as a status read. It then checks two results: the read returns the older contents without the new bit, and the following read returns the new bit. The checker also asserts that the status word after every status read equals exactly the events detected in that cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int EVT_SEL_W = 3;

  typedef enum logic [EVT_SEL_W-1:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } evt_code_e;

  localparam logic [7:0] OFS_IEN   = 8'h20;
  localparam logic [7:0] OFS_IDIS  = 8'h24;
  localparam logic [7:0] OFS_IMASK = 8'h28;
  localparam logic [7:0] OFS_ISTAT = 8'h2C;
endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [NLINES-1:0]           pad_lvl_i,
  input  logic [NLINES*EVT_SEL_W-1:0] evt_sel_i,
  output logic [NLINES-1:0]           hit_o
);
  logic [NLINES-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= pad_lvl_i;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic      h;
    evt_code_e code;
    assign code = evt_code_e'(evt_sel_i[i*EVT_SEL_W +: EVT_SEL_W]);
    always_comb begin
      case (code)
        EV_FALL: h = prev_q[i] & ~pad_lvl_i[i];
        EV_RISE: h = ~prev_q[i] & pad_lvl_i[i];
        EV_BOTH: h = prev_q[i] ^ pad_lvl_i[i];
        EV_LOW:  h = ~pad_lvl_i[i];
        EV_HIGH: h = pad_lvl_i[i];
        default: h = 1'b0;
      endcase
    end
    assign hit_o[i] = h;
  end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NLINES-1:0] wdata_i,
  input  logic [NLINES-1:0] hit_i,
  output logic [NLINES-1:0] stat_o,
  output logic [NLINES-1:0] mask_o,
  output logic [NLINES-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_IDIS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_IMASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_ISTAT);

  logic [NLINES-1:0] mask_q, mask_d, stat_q, stat_d, rdata_q;
  logic              irq_q;
  logic              rd_stat;

  assign rd_stat = rd_i && (addr_i == A_STAT);

  always_comb begin
    mask_d = mask_q;
    if (wr_i && addr_i == A_EN)  mask_d = mask_q | wdata_i;
    if (wr_i && addr_i == A_DIS) mask_d = mask_q & ~wdata_i;
    stat_d = (rd_stat ? '0 : stat_q) | hit_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mask_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
      irq_q  <= |(stat_d & mask_d);
      if (rd_i && addr_i == A_MASK) rdata_q <= mask_q;
      else if (rd_stat)             rdata_q <= stat_q;
      else                          rdata_q <= '0;
    end
  end

  assign stat_o  = stat_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [NLINES-1:0]           pad_lvl_i,
  input  logic [NLINES*EVT_SEL_W-1:0] evt_sel_i,
  input  logic                        bus_wr_i,
  input  logic                        bus_rd_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [NLINES-1:0]           bus_wdata_i,
  output logic [NLINES-1:0]           bus_rdata_o,
  output logic                        irq_o
);
  logic [NLINES-1:0] hit;
  logic [NLINES-1:0] stat_q;
  logic [NLINES-1:0] mask_q;

  gpio_evt_detect #(.NLINES(NLINES)) u_detect (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pad_lvl_i (pad_lvl_i),
    .evt_sel_i (evt_sel_i),
    .hit_o     (hit)
  );

  gpio_evt_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .hit_i   (hit),
    .stat_o  (stat_q),
    .mask_o  (mask_q),
    .rdata_o (bus_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/gpio_evt_irq_chk.sv
module gpio_evt_irq_chk
  import gpio_evt_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NLINES-1:0] bus_wdata_i,
  input logic              irq_i,
  input logic [NLINES-1:0] stat_i,
  input logic [NLINES-1:0] mask_i,
  input logic [NLINES-1:0] hit_i
);
  logic rd_stat, wr_en, wr_dis;
  assign rd_stat = bus_rd_i && (bus_addr_i == ADDR_W'(OFS_ISTAT));
  assign wr_en   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_IEN));
  assign wr_dis  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_IDIS));

  AST_IRQ_MATCHES_PENDING: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i == |(stat_i & mask_i)); // R11

  AST_READ_KEEPS_ONLY_NEW: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_stat |=> stat_i == $past(hit_i)); // R10

  AST_STATUS_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_stat |=> (stat_i & $past(stat_i)) == $past(stat_i)); // R9

  AST_EVENT_RECORDED: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (stat_i & $past(hit_i)) == $past(hit_i)); // R11

  AST_ENABLE_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en |=> (mask_i & $past(bus_wdata_i)) == $past(bus_wdata_i)); // R8

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_dis |=> (mask_i & $past(bus_wdata_i)) == '0); // R8
endmodule

bind gpio_evt_irq gpio_evt_irq_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_i       (irq_o),
  .stat_i      (stat_q),
  .mask_i      (mask_q),
  .hit_i       (hit)
);

// File: tb/gpio_evt_irq_bench.sv
module gpio_evt_irq_bench;
  localparam int N = 32;
  localparam logic [7:0] A_EN = 8'h20, A_DIS = 8'h24, A_MASK = 8'h28, A_STAT = 8'h2C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [N-1:0]   pad = '0;
  logic [3*N-1:0] sel = '0;
  logic           wr = 1'b0, rd = 1'b0;
  logic [7:0]     addr = '0;
  logic [N-1:0]   wdata = '0;
  logic [N-1:0]   rdata;
  logic           irq;
  logic [N-1:0]   got;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  gpio_evt_irq u_gpio_evt_irq (
    .clk_i(clk), .rst_i(rst), .pad_lvl_i(pad), .evt_sel_i(sel),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  // Stimulus table: selector code, level before, level after.
  localparam logic [2:0]   T_CODE [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [N-1:0] T_A    [8] = '{32'hF0F0_3C3C, 32'h0F0F_C3C3, 32'hAAAA_0000,
                                          32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [N-1:0] T_B    [8] = '{32'hFF00_5A5A, 32'hFF00_5A5A, 32'h5555_FFFF,
                                          32'hFF00_F0F0, 32'h00FF_A5A5, 32'hFFFF_0000,
                                          32'h0000_0000, 32'hFFFF_FFFF};
  localparam string        T_REQ  [8] = '{"R2", "R3", "R4", "R5", "R6", "R7", "R7", "R7"};

  function automatic logic [N-1:0] model(input logic [2:0] c, input logic [N-1:0] a, input logic [N-1:0] b);
    case (c)
      3'd0:    return a & ~b;
      3'd1:    return ~a & b;
      3'd2:    return a ^ b;
      3'd3:    return ~b;
      3'd4:    return b;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic fill_sel(input logic [2:0] c);
    sel = {N{c}};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {31'd0, irq}, '0);
    bus_read(A_MASK, got); check("R1 mask after reset", got, '0);
    bus_read(A_STAT, got); check("R1 status after reset", got, '0);

    // Table walk: R2..R7
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); fill_sel(T_CODE[i]); pad = T_A[i];
      @(negedge clk);
      @(negedge clk); pad = T_B[i]; rd = 1'b1; addr = A_STAT;
      @(negedge clk);
      @(negedge clk); rd = 1'b0; got = rdata;
      check(T_REQ[i], got, model(T_CODE[i], T_A[i], T_B[i]));
    end

    // R8 mask set/clear
    bus_write(A_EN, 32'h0000_00FF);
    bus_read(A_MASK, got); check("R8 enable", got, 32'h0000_00FF);
    bus_write(A_EN, 32'h0000_0F00);
    bus_read(A_MASK, got); check("R8 enable keeps", got, 32'h0000_0FFF);
    bus_write(A_DIS, 32'h0000_000F);
    bus_read(A_MASK, got); check("R8 disable", got, 32'h0000_0FF0);

    // R11/R12: masked line sets status but no irq; enabled line raises irq
    @(negedge clk); fill_sel(3'd1); pad = '0;
    @(negedge clk);
    bus_read(A_STAT, got);
    @(negedge clk); pad = 32'h0000_0001;
    @(negedge clk); check("R11 masked line no irq", {31'd0, irq}, '0);
    bus_read(A_STAT, got); check("R11 masked line status", got, 32'h0000_0001);
    @(negedge clk); pad = 32'h0000_0011;
    @(negedge clk); check("R12 irq on enabled event", {31'd0, irq}, 32'd1);
    bus_read(A_STAT, got); check("R9 status read", got, 32'h0000_0010);
    check("R9 irq drops after read", {31'd0, irq}, '0);

    // R9 status holds, mask read does not clear
    @(negedge clk); pad = 32'h0010_0011;
    repeat (5) @(negedge clk);
    bus_read(A_MASK, got); check("R9 mask read", got, 32'h0000_0FF0);
    bus_read(A_STAT, got); check("R9 status held", got, 32'h0010_0000);

    // R10 event in same cycle as status read
    @(negedge clk); pad = 32'h0010_0111; rd = 1'b1; addr = A_STAT;
    @(negedge clk); rd = 1'b0;
    check("R10 read excludes new event", rdata, '0);
    bus_read(A_STAT, got); check("R10 event survives clear", got, 32'h0000_0100);

    // R5 level persists across reads
    @(negedge clk); fill_sel(3'd3); pad = 32'hFFFF_FFFE;
    @(negedge clk);
    bus_read(A_STAT, got); check("R5 low level", got, 32'h0000_0001);
    bus_read(A_STAT, got); check("R5 low level returns", got, 32'h0000_0001);

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; fill_sel(3'd5);
    bus_read(A_MASK, got); check("R1 mask after second reset", got, '0);
    check("R1 irq after second reset", {31'd0, irq}, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule